// File: doc/BRIEF.md
# Write-Buffer Status Timer

This block produces the 32-bit status word that software polls while feeding a slow peripheral bus through a write buffer. No buffer is modelled. Three status flags are produced by cycle timers, and each bus word write starts or stretches those timers. The busy flag rises at once and clears a short while after the most recent write. The middle flag opens its own window a little later. The late flag opens and closes later again. When writes arrive back to back, the windows of the middle and late flags are extended instead of restarted.

Time is a free-running cycle counter of `CNT_W` bits. Each timer stores an absolute "on" and "off" instant. Instants are compared by the sign of their difference, so the counter may wrap.

Each flag has two small state machines:

- **Phase FSM**: `PH_CLOSED`, `PH_ARMED`, `PH_OPEN`.
  - A write that finds the window closed (restart), or any write in restart mode, goes to `PH_ARMED`.
  - A write that finds the window still live keeps the phase.
  - Without a write: `PH_ARMED` goes to `PH_OPEN` when the on instant is reached, and `PH_ARMED` or `PH_OPEN` goes to `PH_CLOSED` when the off instant is reached.
  - `PH_CLOSED` is sticky until the next write, so stale timers are never compared again.
- **Level FSM**: `LVL_LOW`, `LVL_HIGH`. This is the value shown on the status word.
  - A write on the busy flag goes to `LVL_HIGH`.
  - A read goes to `LVL_LOW` if the off instant is reached.
  - Otherwise a read goes to `LVL_HIGH` if the on instant is reached.
  - Otherwise the level holds.

Top module: `wbuf_status_timer`

## Requirements
- R1: A write strobe sets status bit 5 in the cycle after the strobe, whether or not a read is present.
- R2: Bit 5 reads 0 on a read made 8 or more cycles after the latest write, and 1 on a read made sooner.
- R3: A write made when the bit 4 window has closed (off instant strictly before now) places the bit 4 on instant 8 cycles and the off instant 16 cycles after the write.
- R4: A write made when the bit 4 off instant is at or after now (equal counts as live) moves that off instant 16 cycles later and leaves the on instant unchanged.
- R5: A write made when the bit 0 window has closed places the bit 0 on instant 24 cycles after the write and the off instant 24 cycles after that.
- R6: A write made while the bit 0 window is live moves only its off instant, by 24 cycles.
- R7: A read updates each flag as follows: 0 if its off instant is at or before now, else 1 if its on instant is at or before now, else its previous value. The status word shows the result in the next cycle. Without a read or write, the status word does not change.
- R8: When a read and a write fall in the same cycle, the read is evaluated against the timers as they were before that write.
- R9: Status bits other than 5, 4 and 0 always read 0.
- R10: Reset clears the status word to 0 and closes every window.
- R11: Behaviour does not depend on the absolute counter value. This holds across counter wrap and after idle periods longer than half the counter range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | One bus word written this cycle |
| rd_stb_i | input | 1 | Status word read this cycle |
| stat_o | output | STAT_W | Status word (bits 5, 4, 0 used) |

## Verification
A wrong timer or phase shows at the ports only on a read. A corrupted instant therefore appears as a flag that opens or closes on the wrong cycle, and it is visible on the status word one cycle after the first read that lands between the true and the wrong instant. The directed reads are placed on both sides of every instant, on the cycle where an instant equals the write time, and after a counter wrap. This turns an off-by-one or a wrong comparison into a one-cycle mismatch. A wrong level state persists silently until the next read, so reads that fall in the keep region check that the old value survives.

// File: rtl/wst_pkg.sv
package wst_pkg;

    typedef enum logic [1:0] {
        PH_CLOSED = 2'd0,
        PH_ARMED  = 2'd1,
        PH_OPEN   = 2'd2
    } win_phase_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } win_level_e;

    localparam int NUM_WIN = 3;

endpackage

// File: rtl/wst_cycle_count.sv
module wst_cycle_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] now_o
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_o <= '0;
        end else begin
            now_o <= now_o + STEP;
        end
    end

    // R11: time advances by exactly one per cycle, wrap included
    a_r11_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> now_o == CNT_W'($past(now_o) + STEP));

endmodule

// File: rtl/wst_window.sv
module wst_window
    import wst_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int ON_DLY    = 8,
    parameter int OFF_DLY   = 16,
    parameter int EXT_DLY   = 16,
    parameter bit RESTART   = 1'b0,
    parameter bit SET_ON_WR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now_i,
    input  logic             wr_i,
    input  logic             rd_i,
    output logic             level_o
);

    localparam logic [CNT_W-1:0] ON_INC  = CNT_W'(ON_DLY);
    localparam logic [CNT_W-1:0] OFF_INC = CNT_W'(OFF_DLY);
    localparam logic [CNT_W-1:0] EXT_INC = CNT_W'(EXT_DLY);
    localparam int               MSB     = CNT_W - 1;

    logic [CNT_W-1:0] on_q, off_q;
    logic [CNT_W-1:0] d_on, d_off, span;
    logic             on_ge, off_ge, off_gt;
    logic             on_reached, off_reached, expired, fresh;

    win_phase_e phase_q, phase_d;
    win_level_e level_q, level_d;

    // signed-difference comparisons against the running count
    assign d_on   = now_i - on_q;
    assign d_off  = now_i - off_q;
    assign span   = off_q - on_q;
    assign on_ge  = ~d_on[MSB];
    assign off_ge = ~d_off[MSB];
    assign off_gt = off_ge && (d_off != '0);

    assign off_reached = (phase_q == PH_CLOSED) || off_ge;
    assign on_reached  = (phase_q == PH_OPEN)   || on_ge;
    assign expired     = (phase_q == PH_CLOSED) || off_gt;
    assign fresh       = RESTART || expired;

    // timer instants
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q  <= '0;
            off_q <= '0;
        end else if (wr_i) begin
            if (fresh) begin
                on_q  <= now_i + ON_INC;
                off_q <= now_i + OFF_INC;
            end else begin
                off_q <= off_q + EXT_INC;
            end
        end
    end

    // phase next state
    always_comb begin
        phase_d = phase_q;
        if (wr_i) begin
            phase_d = fresh ? PH_ARMED : phase_q;
        end else begin
            unique case (phase_q)
                PH_CLOSED: phase_d = PH_CLOSED;
                PH_ARMED: begin
                    if (off_ge)     phase_d = PH_CLOSED;
                    else if (on_ge) phase_d = PH_OPEN;
                end
                PH_OPEN: begin
                    if (off_ge) phase_d = PH_CLOSED;
                end
                default: phase_d = PH_CLOSED;
            endcase
        end
    end

    // level next state (read evaluation uses pre-write timers)
    always_comb begin
        level_d = level_q;
        if (wr_i && SET_ON_WR) begin
            level_d = LVL_HIGH;
        end else if (rd_i) begin
            if (off_reached)     level_d = LVL_LOW;
            else if (on_reached) level_d = LVL_HIGH;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_CLOSED;
            level_q <= LVL_LOW;
        end else begin
            phase_q <= phase_d;
            level_q <= level_d;
        end
    end

    // output
    always_comb begin
        level_o = (level_q == LVL_HIGH);
    end

    // R7: a read after the off instant leaves the flag low
    a_r7_closed_read_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && phase_q == PH_CLOSED) |=> level_q == LVL_LOW);

    // R5: after any write the on instant precedes the off instant
    a_r5_on_precedes_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (!span[MSB] && span != '0));

    // R11: a closed window stays closed until a write arrives
    a_r11_closed_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CLOSED && !wr_i) |=> phase_q == PH_CLOSED);

endmodule

// File: rtl/wbuf_status_timer.sv
module wbuf_status_timer
    import wst_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int STAT_W   = 32,
    parameter int BUSY_BIT = 5,
    parameter int MID_BIT  = 4,
    parameter int LATE_BIT = 0,
    parameter int BUSY_OFF = 8,
    parameter int MID_ON   = 8,
    parameter int MID_LEN  = 16,
    parameter int LATE_ON  = 24,
    parameter int LATE_LEN = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic              rd_stb_i,
    output logic [STAT_W-1:0] stat_o
);

    localparam int WIN_POS [NUM_WIN] = '{LATE_BIT, MID_BIT, BUSY_BIT};
    localparam int WIN_ON  [NUM_WIN] = '{LATE_ON, MID_ON, 0};
    localparam int WIN_OFF [NUM_WIN] = '{LATE_ON + LATE_LEN, MID_LEN, BUSY_OFF};
    localparam int WIN_EXT [NUM_WIN] = '{LATE_LEN, MID_LEN, BUSY_OFF};
    localparam bit WIN_RST [NUM_WIN] = '{1'b0, 1'b0, 1'b1};
    localparam bit WIN_SET [NUM_WIN] = '{1'b0, 1'b0, 1'b1};

    localparam logic [STAT_W-1:0] USED_MASK =
        (STAT_W'(1) << BUSY_BIT) | (STAT_W'(1) << MID_BIT) | (STAT_W'(1) << LATE_BIT);

    logic [CNT_W-1:0]   now;
    logic [NUM_WIN-1:0] win_lvl;

    wst_cycle_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now)
    );

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        wst_window #(
            .CNT_W     (CNT_W),
            .ON_DLY    (WIN_ON[gi]),
            .OFF_DLY   (WIN_OFF[gi]),
            .EXT_DLY   (WIN_EXT[gi]),
            .RESTART   (WIN_RST[gi]),
            .SET_ON_WR (WIN_SET[gi])
        ) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .now_i   (now),
            .wr_i    (wr_stb_i),
            .rd_i    (rd_stb_i),
            .level_o (win_lvl[gi])
        );
    end

    always_comb begin
        stat_o = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            stat_o[WIN_POS[i]] = win_lvl[i];
        end
    end

    // R1: a write shows as busy on the next cycle
    a_r1_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_i |=> stat_o[BUSY_BIT]);

    // R9: spare bits stay clear
    a_r9_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o & ~USED_MASK) == '0);

    // R7: without an access the word holds
    a_r7_hold_without_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb_i && !rd_stb_i) |=> $stable(stat_o));

endmodule

// File: tb/wbuf_status_timer_tb.sv
`timescale 1ns/1ps
module wbuf_status_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] stat;

    int checks = 0;
    int errors = 0;
    int rel = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wbuf_status_timer #(.CNT_W(8)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr),
        .rd_stb_i (rd),
        .stat_o   (stat)
    );

    task automatic step(input logic w, input logic r);
        wr = w;
        rd = r;
        @(posedge clk);
        #1;
        wr = 1'b0;
        rd = 1'b0;
        rel++;
    endtask

    task automatic go_to(input int d);
        while (rel < d) step(1'b0, 1'b0);
    endtask

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (stat !== exp) begin
            errors++;
            $display("FAIL %s at d=%0d: got %h expected %h", tag, rel - 1, stat, exp);
        end
    endtask

    task automatic settle();
        repeat (110) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        rel = 0;
    endtask

    task automatic t_reset();
        check("R10 reset word", 32'h0);
        step(1'b0, 1'b1);
        check("R10 read after reset", 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] e;
        settle();
        step(1'b1, 1'b0);
        check("R1 busy after write", 32'h20);
        for (int d = 1; d <= 50; d++) begin
            step(1'b0, 1'b1);
            e = 32'h0;
            if (d < 8) e[5] = 1'b1;
            if (d >= 8 && d < 16) e[4] = 1'b1;
            if (d >= 24 && d < 48) e[0] = 1'b1;
            check("R2 R3 R5 R9 single write", e);
        end
    endtask

    task automatic t_keep();
        settle();
        step(1'b1, 1'b0);
        check("R1 busy", 32'h20);
        go_to(10); step(1'b0, 1'b1);
        check("R7 read mid open", 32'h10);
        go_to(20);
        check("R7 hold without read", 32'h10);
        step(1'b1, 1'b0);
        check("R1 busy with kept bit4", 32'h30);
        go_to(22); step(1'b0, 1'b1);
        check("R7 keep before on", 32'h30);
        go_to(25); step(1'b0, 1'b1);
        check("R6 late opens", 32'h31);
        go_to(50); step(1'b0, 1'b1);
        check("R6 late extended", 32'h01);
        go_to(72); step(1'b0, 1'b1);
        check("R6 late closes", 32'h0);
    endtask

    task automatic t_burst();
        settle();
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        go_to(9);  step(1'b0, 1'b1); check("R2 latest write", 32'h30);
        step(1'b0, 1'b1);            check("R2 busy clears", 32'h10);
        go_to(47); step(1'b0, 1'b1); check("R4 mid stretched", 32'h11);
        step(1'b0, 1'b1);            check("R4 mid closes", 32'h01);
        go_to(95); step(1'b0, 1'b1); check("R6 late stretched", 32'h01);
        step(1'b0, 1'b1);            check("R6 late closes", 32'h0);
    endtask

    task automatic t_edge();
        settle();
        step(1'b1, 1'b0);
        go_to(16); step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check("R4 off equal now is live", 32'h30);
    endtask

    task automatic t_late_restart();
        settle();
        step(1'b1, 1'b0);
        go_to(30); step(1'b0, 1'b1); check("R5 late open", 32'h01);
        go_to(49); step(1'b1, 1'b0); check("R1 busy", 32'h21);
        step(1'b0, 1'b1);            check("R5 restart keeps", 32'h21);
        go_to(73); step(1'b0, 1'b1); check("R5 restarted on", 32'h01);
        go_to(97); step(1'b0, 1'b1); check("R5 restarted off", 32'h0);
    endtask

    task automatic t_same();
        settle();
        step(1'b1, 1'b1);
        check("R8 rd wr together fresh", 32'h20);
        settle();
        step(1'b1, 1'b0);
        go_to(16); step(1'b1, 1'b1);
        check("R8 read uses old timers", 32'h20);
    endtask

    task automatic t_wrap();
        repeat (300) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check("R11 long idle", 32'h0);
        rel = 0;
        step(1'b1, 1'b0);
        go_to(10); step(1'b0, 1'b1); check("R11 after wrap mid", 32'h10);
        go_to(30); step(1'b0, 1'b1); check("R11 after wrap late", 32'h01);
    endtask

    task automatic t_reset_mid();
        settle();
        step(1'b1, 1'b0);
        go_to(10); step(1'b0, 1'b1);
        check("R10 before reset", 32'h10);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10 word in reset", 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(1'b0, 1'b1);
        check("R10 windows closed", 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_keep();
        t_burst();
        t_edge();
        t_late_restart();
        t_same();
        t_wrap();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule